// File: doc/BRIEF.md
# Two-Level Chained Interrupt Controller

This block gathers interrupt requests in two tiers and drives one interrupt line. A secondary group of sources is watched for rising edges. Each edge sets a sticky cause bit, and software clears that bit by writing a zero to its position. A per-bit enable mask picks which of these sticky bits count toward a single summary request. That summary request becomes the top bit of the primary cause word. The other primary bits follow the current, synchronized level of the primary sources. They are read-only and cannot be cleared. A second mask over the primary cause word picks which bits raise the registered interrupt output.

Software reaches the four registers through a plain address, write-enable and data port. Reads are combinational on the address. Writes take effect at the next clock edge. Raw sources are asynchronous and each passes through a synchronizer chain first. No data moves through the block as a stream, so the port has no valid/ready handshake and is never back-pressured. Every pin is a plain control or status signal.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A secondary cause bit is set one clock after the synchronized copy of its source goes from 0 to 1. The synchronized copy lags the raw input by SYNC_STAGES clocks. The secondary cause register is read at byte offset 8, with bit i belonging to secondary source i.
- R2: A set secondary cause bit stays set when its source falls. If it is cleared while the source stays high, it does not set again until the next 0-to-1 transition.
- R3: A write to offset 8 clears every secondary cause bit where the written data holds 0. Bits where the data holds 1 keep their value.
- R4: The secondary mask sits at offset 12, is read back as written, and has no effect on whether secondary cause bits are set.
- R5: Primary cause bits 0 to MAIN_W-2 at offset 0 show the synchronized level of the matching primary source. Writes to offset 0 change nothing.
- R6: Primary cause bit MAIN_W-1 is 1 exactly when at least one secondary cause bit is set together with its secondary mask bit.
- R7: The primary mask sits at offset 4 and is read back as written. irq_out is a register, equal to the OR of (primary cause AND primary mask) as it stood in the previous clock.
- R8: When a rising edge and a write-zero clear reach the same secondary bit in the same clock, the bit ends up set.
- R9: Synchronous reset clears the synchronizers, the previous-value state, both cause registers, both masks and irq_out.
- R10: Reads from any offset other than 0, 4, 8 and 12 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte offset of the register for read and write |
| wr_en | input | 1 | Write strobe for the register at addr |
| wr_data | input | DW | Write data (DW is the larger of BR_W and MAIN_W) |
| rd_data | output | DW | Combinational read data for the register at addr |
| br_src | input | BR_W | Raw secondary interrupt sources, edge-detected |
| main_src | input | MAIN_W-1 | Raw primary interrupt sources, level-sensitive |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Directed patterns cover several cases. A source pulse with the mask closed shows that capture is separate from propagation. A source held high across a clear shows edge behaviour rather than level behaviour. A write of mixed ones and zeros separates clear-on-zero from plain overwrite. A rising edge timed to land on the same clock as a clear shows which of the two wins. Writes to the read-only primary cause, reads of unmapped offsets and a mid-run reset complete the directed set. A long phase then drives random source toggles and random writes. Each register read and irq_out is compared on every clock against a cycle-level reference model, which shows any lag or lead in the synchronizer, edge or output stages.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // Byte offsets of the four registers
  localparam int unsigned OFF_MAIN_CAUSE = 0;
  localparam int unsigned OFF_MAIN_MASK  = 4;
  localparam int unsigned OFF_BR_CAUSE   = 8;
  localparam int unsigned OFF_BR_MASK    = 12;

  typedef enum logic [2:0] {
    SEL_MAIN_CAUSE,
    SEL_MAIN_MASK,
    SEL_BR_CAUSE,
    SEL_BR_MASK,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(int unsigned a);
    case (a)
      OFF_MAIN_CAUSE: return SEL_MAIN_CAUSE;
      OFF_MAIN_MASK:  return SEL_MAIN_MASK;
      OFF_BR_CAUSE:   return SEL_BR_CAUSE;
      OFF_BR_MASK:    return SEL_BR_MASK;
      default:        return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic         clr_en,
  input  logic [W-1:0] keep,
  output logic [W-1:0] cause,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;
  logic [W-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // One sticky latch per source; a new edge outranks a clear
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                   cause_q[b] <= 1'b0;
      else if (rise[b])          cause_q[b] <= 1'b1;
      else if (clr_en && !keep[b]) cause_q[b] <= 1'b0;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int BR_W        = 8,
  parameter int MAIN_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  localparam int DW         = (BR_W > MAIN_W) ? BR_W : MAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [BR_W-1:0]   br_src,
  input  logic [MAIN_W-2:0] main_src,
  output logic              irq_out
);

  reg_sel_e sel;
  assign sel = decode_addr(int'(addr));

  logic [BR_W-1:0]   br_lvl;
  logic [BR_W-1:0]   br_cause;
  logic [BR_W-1:0]   br_rise;
  logic [BR_W-1:0]   br_mask;
  logic [MAIN_W-2:0] main_lvl;
  logic [MAIN_W-1:0] main_cause;
  logic [MAIN_W-1:0] main_mask;
  logic              br_summary;
  logic              irq_q;

  irq_sync #(.W(BR_W), .STAGES(SYNC_STAGES)) u_br_sync (
    .clk (clk), .rst (rst), .d (br_src), .q (br_lvl)
  );

  irq_sync #(.W(MAIN_W-1), .STAGES(SYNC_STAGES)) u_main_sync (
    .clk (clk), .rst (rst), .d (main_src), .q (main_lvl)
  );

  irq_edge_bank #(.W(BR_W)) u_br_bank (
    .clk    (clk),
    .rst    (rst),
    .lvl    (br_lvl),
    .clr_en (wr_en && sel == SEL_BR_CAUSE),
    .keep   (wr_data[BR_W-1:0]),
    .cause  (br_cause),
    .rise   (br_rise)
  );

  assign br_summary = |(br_cause & br_mask);
  assign main_cause = {br_summary, main_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      br_mask   <= '0;
      main_mask <= '0;
    end else if (wr_en) begin
      if (sel == SEL_BR_MASK)   br_mask   <= wr_data[BR_W-1:0];
      if (sel == SEL_MAIN_MASK) main_mask <= wr_data[MAIN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(main_cause & main_mask);
  end

  assign irq_out = irq_q;

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_MAIN_CAUSE: rd_data[MAIN_W-1:0] = main_cause;
      SEL_MAIN_MASK:  rd_data[MAIN_W-1:0] = main_mask;
      SEL_BR_CAUSE:   rd_data[BR_W-1:0]   = br_cause;
      SEL_BR_MASK:    rd_data[BR_W-1:0]   = br_mask;
      default:        rd_data             = '0;
    endcase
  end

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk
  import irq_chain_pkg::*;
#(
  parameter int BR_W   = 8,
  parameter int MAIN_W = 8,
  parameter int ADDR_W = 4,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              irq_out,
  input logic [MAIN_W-1:0] main_cause,
  input logic [MAIN_W-1:0] main_mask,
  input logic [BR_W-1:0]   br_cause,
  input logic [BR_W-1:0]   br_rise
);

  logic br_clr_wr;
  logic main_mask_wr;
  assign br_clr_wr    = wr_en && (addr == ADDR_W'(OFF_BR_CAUSE));
  assign main_mask_wr = wr_en && (addr == ADDR_W'(OFF_MAIN_MASK));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !br_clr_wr |=> ((br_cause & $past(br_cause)) == $past(br_cause)));

  // R3
  keep_ones_chk: assert property (@(posedge clk) disable iff (rst)
    br_clr_wr |=> ((br_cause & $past(br_cause & wr_data[BR_W-1:0]))
                   == $past(br_cause & wr_data[BR_W-1:0])));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (br_clr_wr && (|br_rise)) |=> ((br_cause & $past(br_rise)) == $past(br_rise)));

  // R1
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|br_rise) |=> ((br_cause & $past(br_rise)) == $past(br_rise)));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(main_cause & main_mask))));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !main_mask_wr |=> $stable(main_mask));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (br_cause == '0 && main_mask == '0 && !irq_out));

endmodule

bind irq_chain_ctrl irq_chain_chk #(
  .BR_W   (BR_W),
  .MAIN_W (MAIN_W),
  .ADDR_W (ADDR_W),
  .DW     (DW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .irq_out    (irq_out),
  .main_cause (main_cause),
  .main_mask  (main_mask),
  .br_cause   (br_cause),
  .br_rise    (br_rise)
);

// File: tb/tb_irq_chain_ctrl.sv
module tb_irq_chain_ctrl;

  localparam int BR_W   = 8;
  localparam int MAIN_W = 8;
  localparam int SYNC   = 2;
  localparam int ADDR_W = 4;
  localparam int DW     = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [DW-1:0]     wr_data = '0;
  logic [DW-1:0]     rd_data;
  logic [BR_W-1:0]   br_src = '0;
  logic [MAIN_W-2:0] main_src = '0;
  logic              irq_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_ctrl #(
    .BR_W(BR_W), .MAIN_W(MAIN_W), .SYNC_STAGES(SYNC), .ADDR_W(ADDR_W)
  ) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .br_src(br_src), .main_src(main_src), .irq_out(irq_out)
  );

  // ---------------- reference model ----------------
  logic [BR_W-1:0]   bq[$];
  logic [MAIN_W-2:0] mq[$];
  logic [BR_W-1:0]   m_bc = '0, m_bm = '0;
  logic [MAIN_W-1:0] m_mm = '0;
  logic              m_irq = 1'b0;

  function automatic logic [BR_W-1:0] bat(int i);
    return (bq.size() > i) ? bq[i] : '0;
  endfunction
  function automatic logic [MAIN_W-2:0] mat(int i);
    return (mq.size() > i) ? mq[i] : '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bq.delete(); mq.delete();
      m_bc = '0; m_bm = '0; m_mm = '0; m_irq = 1'b0;
    end else begin
      logic [BR_W-1:0] rise;
      bq.push_front(br_src);
      mq.push_front(main_src);
      rise  = bat(SYNC) & ~bat(SYNC+1);
      m_irq = |({|(m_bc & m_bm), mat(SYNC)} & m_mm);
      if (wr_en) begin
        if (addr == 4'd4)  m_mm = wr_data;
        if (addr == 4'd8)  m_bc = m_bc & wr_data;
        if (addr == 4'd12) m_bm = wr_data;
      end
      m_bc = m_bc | rise;
      while (bq.size() > SYNC + 2) void'(bq.pop_back());
      while (mq.size() > SYNC + 2) void'(mq.pop_back());
    end
  end

  function automatic logic [DW-1:0] model_read(logic [ADDR_W-1:0] a);
    case (a)
      4'd0:  return {|(m_bc & m_bm), mat(SYNC-1)};
      4'd4:  return m_mm;
      4'd8:  return m_bc;
      4'd12: return m_bm;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      string tag;
      case (addr)
        4'd0: tag = "R5"; 4'd4: tag = "R7"; 4'd8: tag = "R1";
        4'd12: tag = "R4"; default: tag = "R10";
      endcase
      chk(tag, rd_data, model_read(addr));
      chk("R7", {7'd0, irq_out}, {7'd0, m_irq});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    tick(1); addr = a; wr_data = d; wr_en = 1'b1;
    tick(1); wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [ADDR_W-1:0] a, logic [DW-1:0] exp);
    tick(1); addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- directed and random test ----------------
  initial begin
    tick(4); rst = 1'b0;
    // R9 reset state
    rd_chk("R9", 4'd0, 8'h00); rd_chk("R9", 4'd4, 8'h00);
    rd_chk("R9", 4'd8, 8'h00); rd_chk("R9", 4'd12, 8'h00);
    chk("R9", {7'd0, irq_out}, 8'h00);

    // R4: capture with mask closed; R6 summary stays low
    br_src = 8'h04; tick(SYNC + 3);
    rd_chk("R4", 4'd8, 8'h04);
    rd_chk("R6", 4'd0, 8'h00);

    // R2: sticky after source falls
    br_src = 8'h00; tick(4);
    rd_chk("R2", 4'd8, 8'h04);

    // R3: ones keep, zeros clear
    wr(4'd8, 8'hFF); rd_chk("R3", 4'd8, 8'h04);
    wr(4'd8, 8'hFB); rd_chk("R3", 4'd8, 8'h00);

    // R2: held-high source does not set again after a clear
    br_src = 8'h10; tick(SYNC + 3);
    wr(4'd8, 8'h00); tick(3);
    rd_chk("R2", 4'd8, 8'h00);

    // R6/R7: summary into main bit 7 and the output
    br_src = 8'h00; tick(4);
    br_src = 8'h10; tick(SYNC + 3);
    wr(4'd12, 8'h10); rd_chk("R4", 4'd12, 8'h10);
    rd_chk("R6", 4'd0, 8'h80);
    wr(4'd4, 8'h80); tick(2);
    chk("R7", {7'd0, irq_out}, 8'h01);
    wr(4'd4, 8'h00); tick(2);
    chk("R7", {7'd0, irq_out}, 8'h00);

    // R5: level bits and write-ignore on offset 0
    main_src = 7'h05; tick(SYNC + 2);
    rd_chk("R5", 4'd0, 8'h85);
    wr(4'd0, 8'h00); rd_chk("R5", 4'd0, 8'h85);
    wr(4'd4, 8'h01); tick(2);
    chk("R7", {7'd0, irq_out}, 8'h01);
    main_src = 7'h00; tick(SYNC + 2);
    chk("R7", {7'd0, irq_out}, 8'h00);
    rd_chk("R5", 4'd0, 8'h80);

    // R8: edge lands on the same clock as a clear
    wr(4'd8, 8'h00); br_src = 8'h00; tick(4);
    br_src = 8'h01;
    tick(SYNC); addr = 4'd8; wr_data = 8'h00; wr_en = 1'b1;
    tick(1); wr_en = 1'b0;
    rd_chk("R8", 4'd8, 8'h01);

    // R10: unmapped offsets
    rd_chk("R10", 4'd2, 8'h00); rd_chk("R10", 4'd14, 8'h00);

    // random phase, compared every clock
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      if ($urandom_range(3) == 0) br_src = BR_W'($urandom);
      if ($urandom_range(3) == 0) main_src = (MAIN_W-1)'($urandom);
      wr_en = ($urandom_range(3) == 0);
      case ($urandom_range(5))
        0: addr = 4'd0; 1: addr = 4'd4; 2: addr = 4'd8;
        3: addr = 4'd12; 4: addr = 4'd2; default: addr = 4'd14;
      endcase
      wr_data = DW'($urandom);
    end
    tick(1); wr_en = 1'b0;

    // R9: mid-run reset
    br_src = '0; main_src = '0; rst = 1'b1; tick(3); rst = 1'b0;
    rd_chk("R9", 4'd8, 8'h00); rd_chk("R9", 4'd12, 8'h00);
    rd_chk("R9", 4'd4, 8'h00); rd_chk("R9", 4'd0, 8'h00);
    chk("R9", {7'd0, irq_out}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule